// File: doc/BRIEF.md
# Selective Tournament Branch Direction Predictor

This block predicts the direction of conditional branches. Two component predictors run side by side. One is a table of 2-bit saturating counters addressed only by the branch address. The other is a correlating table addressed by the recent global taken/not-taken history joined with low address bits. A third table of 2-bit chooser counters, also addressed by the branch address, records which component has the better record for each branch. The final prediction follows that chooser.

A lookup presents a branch word address and returns, in the same cycle, the final prediction and both component predictions. The fetch logic keeps the two component predictions and returns them with the resolved outcome in an update. The update trains both components and the chooser, and it shifts the outcome into the global history. A flush input models the loss of prediction state at a context switch. After a flush the chooser favours the address-only component, which relearns quickly, until the correlating component has shown that it does better.

Top module: `tourney_bp`

## Requirements
- R1: The address-only component holds 2^IDX_W 2-bit counters indexed by addr[IDX_W-1:0]. Its prediction is the counter MSB (1 = taken). A valid update adds one on taken and subtracts one on not-taken, saturating at 0 and 3.
- R2: The correlating component holds 2^(HIST_W+GSEL_PC_W) 2-bit counters indexed by {history, addr[GSEL_PC_W-1:0]} and predicts from the counter MSB. Each valid update trains it with the same saturating rule, then shifts the outcome into history bit 0 while older bits move up. Branches whose low GSEL_PC_W address bits match share its entries.
- R3: The final prediction equals the correlating prediction when the chooser counter at addr[IDX_W-1:0] has its MSB set, and otherwise equals the address-only prediction.
- R4: On a valid update the chooser counter moves one step toward the component that was correct, saturating at 0 and 3. It moves only when exactly one component was correct, and it does not change when both were right or both were wrong.
- R5: Reset (rst_ni low) and a one-cycle flush_i both set every component counter to 01 (weakly not-taken), every chooser counter to 00 (strongly favour the address-only component), and the history to 0.
- R6: When upd_valid_i is low, no counter and no history bit changes, whatever the other update inputs carry.
- R7: Chooser training uses the component predictions carried on upd_bim_i and upd_cor_i, not the current table contents.
- R8: The predictions are combinational from pred_addr_i and the current state. An update takes effect on predictions from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all prediction state |
| pred_addr_i | input | IDX_W | Word address of the branch being predicted |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_bim_o | output | 1 | Address-only component prediction |
| pred_cor_o | output | 1 | Correlating component prediction |
| upd_valid_i | input | 1 | Update strobe |
| upd_addr_i | input | IDX_W | Word address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_bim_i | input | 1 | Address-only prediction made for this branch |
| upd_cor_i | input | 1 | Correlating prediction made for this branch |

## Verification
The bench builds the block with IDX_W=6, HIST_W=2 and GSEL_PC_W=4. This gives a 2-bit-history correlating table, so one branch spreads its training over four entries. The address field is narrow enough that two distinct branches can be made to share correlating entries. A short alternating branch is enough to drive the chooser from its reset value over to the correlating side. Injected update predictions make chooser movement, and the lack of it, visible at the outputs within a few cycles.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT    = 2'b01;
  localparam ctr2_t CTR_STRONG_BIM = 2'b00;

  function automatic ctr2_t sat_step(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/tbp_ctr_tbl.sv
module tbp_ctr_tbl
  import tbp_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr2_t            rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= sat_step(mem_q[wr_idx_i], wr_up_i);
    end
  end

  assign rd_ctr_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (flush_i) hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int HIST_W    = 2,
  parameter int GSEL_PC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] pred_addr_i,
  output logic             pred_taken_o,
  output logic             pred_bim_o,
  output logic             pred_cor_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_addr_i,
  input  logic             upd_taken_i,
  input  logic             upd_bim_i,
  input  logic             upd_cor_i
);
  localparam int COR_IDX_W = HIST_W + GSEL_PC_W;

  logic [HIST_W-1:0]    hist_q;
  logic [COR_IDX_W-1:0] cor_rd_idx, cor_wr_idx;
  ctr2_t                bim_ctr, cor_ctr, cho_ctr;
  logic                 bim_ok, cor_ok;

  assign cor_rd_idx = {hist_q, pred_addr_i[GSEL_PC_W-1:0]};
  assign cor_wr_idx = {hist_q, upd_addr_i[GSEL_PC_W-1:0]};

  // chooser trains on the predictions as made, carried with the update
  assign bim_ok = (upd_bim_i == upd_taken_i);
  assign cor_ok = (upd_cor_i == upd_taken_i);

  tbp_ctr_tbl #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NT)) u_bim (
    .clk_i, .rst_ni, .flush_i,
    .rd_idx_i (pred_addr_i),
    .rd_ctr_o (bim_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_addr_i),
    .wr_up_i  (upd_taken_i)
  );

  tbp_ctr_tbl #(.IDX_W(COR_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_cor (
    .clk_i, .rst_ni, .flush_i,
    .rd_idx_i (cor_rd_idx),
    .rd_ctr_o (cor_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (cor_wr_idx),
    .wr_up_i  (upd_taken_i)
  );

  tbp_ctr_tbl #(.IDX_W(IDX_W), .RST_VAL(CTR_STRONG_BIM)) u_cho (
    .clk_i, .rst_ni, .flush_i,
    .rd_idx_i (pred_addr_i),
    .rd_ctr_o (cho_ctr),
    .wr_en_i  (upd_valid_i & (bim_ok ^ cor_ok)),
    .wr_idx_i (upd_addr_i),
    .wr_up_i  (cor_ok)
  );

  tbp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk_i, .rst_ni, .flush_i,
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist_q)
  );

  assign pred_bim_o   = bim_ctr[1];
  assign pred_cor_o   = cor_ctr[1];
  assign pred_taken_o = cho_ctr[1] ? pred_cor_o : pred_bim_o;
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic [IDX_W-1:0]  pred_addr_i,
  input logic              pred_taken_o,
  input logic              pred_bim_o,
  input logic              pred_cor_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_q
);
  AST_AGREE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_bim_o == pred_cor_o) |-> (pred_taken_o == pred_bim_o)); // R3

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!pred_taken_o && !pred_bim_o && !pred_cor_o && hist_q == '0)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && !flush_i) |=>
      (!$stable(pred_addr_i) || $stable({pred_taken_o, pred_bim_o, pred_cor_o}))); // R6

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !flush_i) |=>
      (hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken_i)})); // R2

  AST_HIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && !flush_i) |=> $stable(hist_q)); // R6
endmodule

bind tourney_bp tourney_bp_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .pred_addr_i  (pred_addr_i),
  .pred_taken_o (pred_taken_o),
  .pred_bim_o   (pred_bim_o),
  .pred_cor_o   (pred_cor_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .hist_q       (hist_q)
);

// File: tb/tourney_bp_test.sv
module tourney_bp_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int HIST_W     = 2;
  localparam int GSEL_PC_W  = 4;
  localparam int N_BIM      = 1 << IDX_W;
  localparam int N_COR      = 1 << (HIST_W + GSEL_PC_W);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             flush_i = 1'b0;
  logic [IDX_W-1:0] pred_addr_i = '0;
  logic             pred_taken_o, pred_bim_o, pred_cor_o;
  logic             upd_valid_i = 1'b0;
  logic [IDX_W-1:0] upd_addr_i = '0;
  logic             upd_taken_i = 1'b0;
  logic             upd_bim_i = 1'b0;
  logic             upd_cor_i = 1'b0;

  tourney_bp #(.IDX_W(IDX_W), .HIST_W(HIST_W), .GSEL_PC_W(GSEL_PC_W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model built from the requirements
  bit [1:0] m_bim [N_BIM];
  bit [1:0] m_cor [N_COR];
  bit [1:0] m_cho [N_BIM];
  int       m_hist;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0] exp_q [$];
  string      req_q [$];
  event       chk_ev;

  function automatic int cidx(int a);
    return (m_hist << GSEL_PC_W) | (a & ((1 << GSEL_PC_W) - 1));
  endfunction

  function automatic bit [1:0] sat(bit [1:0] c, bit up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N_BIM; i++) begin m_bim[i] = 2'b01; m_cho[i] = 2'b00; end
    for (int i = 0; i < N_COR; i++) m_cor[i] = 2'b01;
    m_hist = 0;
  endtask

  task automatic model_upd(int a, bit tk, bit b, bit c);
    m_bim[a] = sat(m_bim[a], tk);
    m_cor[cidx(a)] = sat(m_cor[cidx(a)], tk);
    if ((b == tk) != (c == tk)) m_cho[a] = sat(m_cho[a], c == tk);
    m_hist = ((m_hist << 1) | int'(tk)) & ((1 << HIST_W) - 1);
  endtask

  // drive pred_addr, queue expected {final,bim,cor}
  task automatic push_pred(int a, string req, output bit eb, output bit ec);
    bit et;
    pred_addr_i = IDX_W'(a);
    eb = m_bim[a][1];
    ec = m_cor[cidx(a)][1];
    et = m_cho[a][1] ? ec : eb;
    exp_q.push_back({et, eb, ec});
    req_q.push_back(req);
    #1 -> chk_ev;
  endtask

  task automatic br(int a, bit tk, string req);
    bit eb, ec;
    @(negedge clk_i);
    push_pred(a, req, eb, ec);
    upd_valid_i = 1'b1; upd_addr_i = IDX_W'(a); upd_taken_i = tk;
    upd_bim_i = eb; upd_cor_i = ec;
    @(posedge clk_i);
    model_upd(a, tk, eb, ec);
    #1 upd_valid_i = 1'b0;
  endtask

  task automatic probe(int a, string req);
    bit eb, ec;
    @(negedge clk_i);
    push_pred(a, req, eb, ec);
    @(posedge clk_i);
  endtask

  task automatic upd_only(int a, bit tk, bit b, bit c);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_addr_i = IDX_W'(a); upd_taken_i = tk;
    upd_bim_i = b; upd_cor_i = c;
    @(posedge clk_i);
    model_upd(a, tk, b, c);
    #1 upd_valid_i = 1'b0;
  endtask

  task automatic noval(int a, bit tk, bit b, bit c);
    @(negedge clk_i);
    upd_valid_i = 1'b0; upd_addr_i = IDX_W'(a); upd_taken_i = tk;
    upd_bim_i = b; upd_cor_i = c;
    @(posedge clk_i);
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    upd_valid_i = 1'b1; upd_addr_i = '0; upd_taken_i = 1'b1;
    @(posedge clk_i);
    model_reset();
    #1 begin flush_i = 1'b0; upd_valid_i = 1'b0; end
  endtask

  // monitor: compare design outputs against queued expectations
  initial begin
    forever begin
      logic [2:0] e;
      string r;
      @(chk_ev);
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_vec++;
      if ({pred_taken_o, pred_bim_o, pred_cor_o} !== e) begin
        n_bad++;
        $display("FAIL %s addr=%0d {final,bim,cor} got=%b exp=%b", r, pred_addr_i,
                 {pred_taken_o, pred_bim_o, pred_cor_o}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R5 reset state
    probe(6'h05, "R5_reset");
    probe(6'h3f, "R5_reset");

    // R1 biased branch learns after one taken, R8 same-cycle lookup
    for (int i = 0; i < 6; i++) br(6'h10, 1'b1, "R1_R8_biased");

    // R2 R3 R4 alternating branch: address-only always wrong, chooser migrates
    for (int i = 0; i < 24; i++) br(6'h21, (i % 2) == 0, "R2_R3_R4_alt");

    // R1 saturation: one not-taken after many taken keeps the prediction
    for (int i = 0; i < 5; i++) br(6'h10, 1'b1, "R1_sat");
    br(6'h10, 1'b0, "R1_sat");
    probe(6'h10, "R1_sat_hold");

    // R2 shared correlating entries: 0x31 and 0x21 share low 4 bits
    for (int i = 0; i < 4; i++) br(6'h31, 1'b1, "R2_shared");
    probe(6'h21, "R2_shared");

    // R7 chooser follows supplied predictions
    upd_only(6'h0c, 1'b1, 1'b0, 1'b1);
    upd_only(6'h0c, 1'b1, 1'b0, 1'b1);
    probe(6'h0c, "R7_injected");
    // R4 both correct and both wrong leave chooser unchanged
    upd_only(6'h0c, 1'b1, 1'b1, 1'b1);
    upd_only(6'h0c, 1'b0, 1'b1, 1'b1);
    probe(6'h0c, "R4_no_move");
    upd_only(6'h0c, 1'b0, 1'b1, 1'b0);
    upd_only(6'h0c, 1'b0, 1'b1, 1'b0);
    probe(6'h0c, "R4_back");

    // R6 invalid updates change nothing
    noval(6'h10, 1'b0, 1'b1, 1'b1);
    noval(6'h21, 1'b1, 1'b0, 1'b0);
    noval(6'h10, 1'b0, 1'b0, 1'b1);
    probe(6'h10, "R6_ignored");
    probe(6'h21, "R6_ignored");

    // R5 flush wipes learned state even with a concurrent update
    do_flush();
    probe(6'h10, "R5_flush");
    probe(6'h21, "R5_flush");
    probe(6'h0c, "R5_flush");

    // R1 R3 relearn after flush, chooser back on address-only side
    for (int i = 0; i < 3; i++) br(6'h10, 1'b1, "R1_R3_relearn");
    for (int i = 0; i < 8; i++) br(6'h21, (i % 2) == 1, "R3_R4_rewarm");

    repeat (3) @(posedge clk_i);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 monitor queue not drained got=%0d exp=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule